// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox

This block passes 32-bit messages between processors over a simple register bus. It holds a set of small message queues. Any processor may push a word into a queue by writing that queue's message register, and any processor may pop the oldest word by reading the same register. Each queue reports its fill level and whether it is full.

Notification works per user. Every interrupt user has its own status word, its own enable mask and its own interrupt line. Each queue drives two events into every user's status word: a new-message event and a not-full event. Software picks which events reach its line by setting and clearing enable bits, and it acknowledges events with write-one-to-clear.

All registers are 32-bit words at word-aligned byte addresses, and the bus takes one access per cycle. Read data is combinational in the cycle that `bus_rd` is high. A pop, a push or a register update takes effect at the clock edge that ends the access.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every queue is empty, every status and enable bit is zero and every `irq_o` bit is low.
- R2: Address 0x000 reads the constant parameter `REVISION` (default 0x4D420100), and writes to it have no effect.
- R3: A write to 0x040+4*m appends the word to queue m, and a read of 0x040+4*m returns and removes the oldest word, in first-in first-out order.
- R4: Each queue holds `DEPTH` (4) words, and a write to a full queue is dropped without changing its contents.
- R5: A read of an empty queue's message register returns 0 and changes no state.
- R6: Address 0x080+4*m reads 1 while queue m is full and 0 otherwise.
- R7: Address 0x0C0+4*m reads the number of words held in queue m.
- R8: Every accepted push to queue m sets bit 2*m (new message) in the status word of every user.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it alone; a cleared new-message bit sets again one cycle later while its queue still holds data.
- R10: A pop that takes queue m from full to not full sets bit 2*m+1 (not full) in every user's status word, and a pop from a queue that was not full does not set it.
- R11: User u's enable-set register at 0x108+0x10*u sets the enable bits written as 1, its enable-clear register at 0x10C+0x10*u clears them, and both read back the current mask; its status is at 0x104+0x10*u.
- R12: `irq_o[u]` is high exactly when user u has at least one bit set in both its status word and its enable mask.
- R13: Reads of unmapped or misaligned addresses, including queue and user indices beyond the configured counts, return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while `bus_rd` is high |
| irq_o | output | N_USER (3) | One interrupt line per user |

## Verification
The bench overfills a queue and then drains it past empty. A design that wrapped its pointers would return a newer word in place of the oldest one, and one that popped on an empty read would corrupt the count. It clears a new-message bit while data is still queued and reads the status in each of the next two cycles. A design with the wrong priority between clear and set would show the bit either never dropping or never coming back. It pops once from a full queue and once from a queue that is no longer full, which separates a true full-to-not-full edge from a plain pop. It also aims at addresses that sit one index past the configured queues and users, where a decoder that ignored the limits would alias onto a real register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // register region selected by an address
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REV,
        SEL_MSG,
        SEL_FULL,
        SEL_CNT,
        SEL_STAT,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

    // byte offsets of the register regions (behaviour depends on them)
    localparam int unsigned OFS_USER_BASE = 'h100;

    // index width helper: at least one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned N_FIFO = 4,
    parameter int unsigned N_USER = 3,
    localparam int unsigned FW = idx_w(N_FIFO),
    localparam int unsigned UW = idx_w(N_USER)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [FW-1:0]     fifo_o,
    output logic [UW-1:0]     user_o
);

    localparam int unsigned WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] USER_WBASE = WA_W'(OFS_USER_BASE >> 2);

    logic [WA_W-1:0] waddr;
    logic [WA_W-1:0] uword;

    assign waddr = addr_i[ADDR_W-1:2];
    assign uword = waddr - USER_WBASE;

    always_comb begin
        sel_o  = SEL_NONE;
        fifo_o = FW'(waddr[3:0]);
        user_o = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (waddr < USER_WBASE) begin
                // queue regions: bits [7:6] pick the kind, [5:2] the queue
                unique case (waddr[5:4])
                    2'd0: if (waddr[3:0] == 4'd0) sel_o = SEL_REV;
                    2'd1: if (32'(waddr[3:0]) < N_FIFO) sel_o = SEL_MSG;
                    2'd2: if (32'(waddr[3:0]) < N_FIFO) sel_o = SEL_FULL;
                    2'd3: if (32'(waddr[3:0]) < N_FIFO) sel_o = SEL_CNT;
                endcase
            end else if (32'(uword[WA_W-1:2]) < N_USER) begin
                user_o = UW'(uword[WA_W-1:2]);
                unique case (uword[1:0])
                    2'd0: sel_o = SEL_NONE;
                    2'd1: sel_o = SEL_STAT;
                    2'd2: sel_o = SEL_ENSET;
                    2'd3: sel_o = SEL_ENCLR;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] cnt_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          push_ok_o,
    output logic          pop_ok_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    assign full_o    = (st_q.cnt == CW'(DEPTH));
    assign empty_o   = (st_q.cnt == '0);
    assign push_ok_o = push_i && !full_o;
    assign pop_ok_o  = pop_i && !empty_o;
    assign head_o    = empty_o ? '0 : st_q.mem[st_q.rd];
    assign cnt_o     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok_o) begin
            st_d.mem[st_q.wr] = wdata_i;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_ok_o) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push_ok_o) - CW'(pop_ok_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (st_q.cnt == CW'(DEPTH)) && $stable(st_q.mem)); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (st_q.cnt == '0) && $stable(st_q.rd)); // R5

endmodule

// File: rtl/mbx_irq_user.sv
module mbx_irq_user #(
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat_i,
    input  logic          wr_set_i,
    input  logic          wr_clr_i,
    input  logic [IW-1:0] wdata_i,
    input  logic [IW-1:0] evt_i,
    input  logic [IW-1:0] lvl_i,
    output logic [IW-1:0] stat_o,
    output logic [IW-1:0] en_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [IW-1:0] stat;
        logic [IW-1:0] en;
    } user_st_t;

    user_st_t st_d, st_q;
    logic [IW-1:0] ack;

    always_comb begin
        st_d = st_q;
        ack  = wr_stat_i ? wdata_i : '0;
        // clear wins over a level in the ack cycle, a fresh event wins over clear
        st_d.stat = (st_q.stat & ~ack) | evt_i | (lvl_i & ~ack);
        if (wr_set_i)      st_d.en = st_q.en | wdata_i;
        else if (wr_clr_i) st_d.en = st_q.en & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign irq_o  = |(st_q.stat & st_q.en);

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat_i |=> ((st_q.stat & $past(wdata_i & ~evt_i)) == '0)); // R9
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_i |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat))); // R9
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set_i |=> ((st_q.en & $past(wdata_i)) == $past(wdata_i))); // R11
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && !wr_set_i) |=> ((st_q.en & $past(wdata_i)) == '0)); // R11
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_o != '0)); // R12

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned N_FIFO   = 4,
    parameter int unsigned N_USER   = 3,
    parameter int unsigned DEPTH    = 4,
    parameter logic [31:0] REVISION = 32'h4D42_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_USER-1:0] irq_o
);

    localparam int unsigned FW = idx_w(N_FIFO);
    localparam int unsigned UW = idx_w(N_USER);
    localparam int unsigned IW = 2 * N_FIFO;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    reg_sel_e        sel;
    logic [FW-1:0]   fidx;
    logic [UW-1:0]   uidx;

    logic [DATA_W-1:0] f_head [N_FIFO];
    logic [CW-1:0]     f_cnt  [N_FIFO];
    logic [N_FIFO-1:0] f_full, f_empty, f_push_ok, f_pop_ok;
    logic [IW-1:0]     evt, lvl;
    logic [IW-1:0]     u_stat [N_USER];
    logic [IW-1:0]     u_en   [N_USER];

    mbx_decode #(
        .ADDR_W (ADDR_W),
        .N_FIFO (N_FIFO),
        .N_USER (N_USER)
    ) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel),
        .fifo_o (fidx),
        .user_o (uidx)
    );

    for (genvar m = 0; m < N_FIFO; m++) begin : g_fifo
        logic hit;
        assign hit = (sel == SEL_MSG) && (fidx == FW'(m));

        mbx_fifo #(
            .DW    (DATA_W),
            .DEPTH (DEPTH)
        ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (bus_wr && hit),
            .pop_i     (bus_rd && hit),
            .wdata_i   (bus_wdata),
            .head_o    (f_head[m]),
            .cnt_o     (f_cnt[m]),
            .full_o    (f_full[m]),
            .empty_o   (f_empty[m]),
            .push_ok_o (f_push_ok[m]),
            .pop_ok_o  (f_pop_ok[m])
        );

        // event layout: even bit new message, odd bit not full
        assign evt[2*m]   = f_push_ok[m];
        assign evt[2*m+1] = f_pop_ok[m] && f_full[m];
        assign lvl[2*m]   = !f_empty[m];
        assign lvl[2*m+1] = 1'b0;

        AST_NEWMSG_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            f_push_ok[m] |=> u_stat[0][2*m]); // R8
        AST_NOTFULL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (f_pop_ok[m] && f_full[m]) |=> u_stat[N_USER-1][2*m+1]); // R10
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_user
        logic uhit;
        assign uhit = (uidx == UW'(u));

        mbx_irq_user #(
            .IW (IW)
        ) u_irq (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_stat_i (bus_wr && uhit && (sel == SEL_STAT)),
            .wr_set_i  (bus_wr && uhit && (sel == SEL_ENSET)),
            .wr_clr_i  (bus_wr && uhit && (sel == SEL_ENCLR)),
            .wdata_i   (bus_wdata[IW-1:0]),
            .evt_i     (evt),
            .lvl_i     (lvl),
            .stat_o    (u_stat[u]),
            .en_o      (u_en[u]),
            .irq_o     (irq_o[u])
        );
    end

    if (IW < DATA_W) begin : g_wsink
        logic wdata_hi_unused;
        assign wdata_hi_unused = ^bus_wdata[DATA_W-1:IW];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_REV:   bus_rdata = DATA_W'(REVISION);
            SEL_MSG:   bus_rdata = f_head[fidx];
            SEL_FULL:  bus_rdata = DATA_W'(f_full[fidx]);
            SEL_CNT:   bus_rdata = DATA_W'(f_cnt[fidx]);
            SEL_STAT:  bus_rdata = DATA_W'(u_stat[uidx]);
            SEL_ENSET,
            SEL_ENCLR: bus_rdata = DATA_W'(u_en[uidx]);
            default:   bus_rdata = '0;
        endcase
    end

    AST_IRQ_QUIET_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_o == '0)); // R1

endmodule

// File: tb/sim_mbx_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_ctrl;

    localparam logic [31:0] REV = 32'h4D42_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    mbx_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    function automatic logic [11:0] a_msg(int m);  return 12'(32'h040 + 4*m); endfunction
    function automatic logic [11:0] a_full(int m); return 12'(32'h080 + 4*m); endfunction
    function automatic logic [11:0] a_cnt(int m);  return 12'(32'h0C0 + 4*m); endfunction
    function automatic logic [11:0] a_st(int u);   return 12'(32'h104 + 16*u); endfunction
    function automatic logic [11:0] a_set(int u);  return 12'(32'h108 + 16*u); endfunction
    function automatic logic [11:0] a_clr(int u);  return 12'(32'h10C + 16*u); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // each access occupies exactly one cycle, starting at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic clear_all_status();
        for (int u = 0; u < 3; u++) wr(a_st(u), 32'hFF);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 4; m++) begin
            rdchk(a_cnt(m), 0, "R1 count after reset");
            rdchk(a_full(m), 0, "R1 full after reset");
        end
        for (int u = 0; u < 3; u++) begin
            rdchk(a_st(u), 0, "R1 status after reset");
            rdchk(a_set(u), 0, "R1 enable after reset");
        end
        chk("R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_revision();
        rdchk(12'h000, REV, "R2 revision");
        wr(12'h000, 32'hFFFF_FFFF);
        rdchk(12'h000, REV, "R2 revision after write");
    endtask

    task automatic t_order();
        wr(a_msg(1), 32'hA1);
        wr(a_msg(1), 32'hA2);
        wr(a_msg(1), 32'hA3);
        rdchk(a_cnt(1), 3, "R7 count three");
        rdchk(a_msg(1), 32'hA1, "R3 first out");
        rdchk(a_msg(1), 32'hA2, "R3 second out");
        rdchk(a_cnt(1), 1, "R7 count one");
        rdchk(a_msg(1), 32'hA3, "R3 third out");
        rdchk(a_cnt(1), 0, "R7 count drained");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 5; i++) wr(a_msg(0), 32'hB0 + 32'(i));
        rdchk(a_full(0), 1, "R6 full flag set");
        rdchk(a_cnt(0), 4, "R4 depth four");
        for (int i = 0; i < 4; i++) rdchk(a_msg(0), 32'hB0 + 32'(i), "R4 dropped word absent");
        rdchk(a_full(0), 0, "R6 full flag clear");
        rdchk(a_msg(0), 0, "R5 empty read zero");
        rdchk(a_cnt(0), 0, "R5 empty read no change");
        wr(a_msg(0), 32'hBB);
        rdchk(a_msg(0), 32'hBB, "R5 queue intact after empty read");
    endtask

    task automatic t_newmsg();
        clear_all_status();
        rdchk(a_st(0), 0, "R9 status cleared");
        wr(a_msg(2), 32'hC0);
        for (int u = 0; u < 3; u++) rdchk(a_st(u), 32'h10, "R8 new message bit 4 every user");
        wr(a_st(1), 32'h10);
        rdchk(a_st(1), 32'h00, "R9 cleared in ack cycle");
        rdchk(a_st(1), 32'h10, "R9 sets again while not empty");
        wr(a_st(0), 32'h00);
        rdchk(a_st(0), 32'h10, "R9 zero write keeps bit");
        rdchk(a_msg(2), 32'hC0, "R3 pop C0");
        wr(a_st(1), 32'h10);
        rdchk(a_st(1), 32'h00, "R9 cleared when empty");
        rdchk(a_st(1), 32'h00, "R9 stays clear when empty");
        clear_all_status();
    endtask

    task automatic t_notfull();
        for (int i = 0; i < 4; i++) wr(a_msg(3), 32'hD0 + 32'(i));
        wr(a_st(0), 32'hFF);
        rdchk(a_st(0), 32'h00, "R9 all cleared");
        rdchk(a_st(0), 32'h40, "R10 no not-full before pop");
        rdchk(a_msg(3), 32'hD0, "R3 pop D0");
        rdchk(a_st(0), 32'hC0, "R10 not-full bit 7 user0");
        rdchk(a_st(2), 32'hC0, "R10 not-full bit 7 user2");
        wr(a_st(0), 32'hFF);
        rdchk(a_st(0), 32'h00, "R9 cleared again");
        rdchk(a_msg(3), 32'hD1, "R3 pop D1");
        rdchk(a_st(0), 32'h40, "R10 no not-full from non-full pop");
        rdchk(a_msg(3), 32'hD2, "R3 pop D2");
        rdchk(a_msg(3), 32'hD3, "R3 pop D3");
        clear_all_status();
    endtask

    task automatic t_enable();
        wr(a_set(2), 32'h05);
        rdchk(a_set(2), 32'h05, "R11 read via set");
        rdchk(a_clr(2), 32'h05, "R11 read via clear");
        wr(a_clr(2), 32'h01);
        rdchk(a_set(2), 32'h04, "R11 clear one bit");
        rdchk(a_set(0), 32'h00, "R11 other user untouched");
        chk("R12 irq idle", 32'(irq), 0);
        wr(a_msg(1), 32'hE0);
        chk("R12 irq user2 only", 32'(irq), 32'h4);
        wr(a_clr(2), 32'h04);
        chk("R12 irq after disable", 32'(irq), 0);
        wr(a_set(0), 32'h04);
        chk("R12 irq user0 on enable", 32'(irq), 32'h1);
        wr(a_clr(0), 32'hFF);
        rdchk(a_msg(1), 32'hE0, "R3 pop E0");
        clear_all_status();
    endtask

    task automatic t_unmapped();
        rdchk(12'h100, 0, "R13 hole at user base");
        rdchk(12'h004, 0, "R13 hole after revision");
        rdchk(12'h134, 0, "R13 user index past count");
        rdchk(12'h050, 0, "R13 queue index past count");
        rdchk(12'h0D0, 0, "R13 count index past count");
        wr(a_msg(0), 32'hF0);
        rdchk(12'h042, 0, "R13 misaligned message read");
        rdchk(a_cnt(0), 1, "R13 misaligned read no pop");
        wr(12'h050, 32'h1234);
        wr(12'h046, 32'h5678);
        for (int m = 1; m < 4; m++) rdchk(a_cnt(m), 0, "R13 write to hole no push");
        rdchk(a_cnt(0), 1, "R13 misaligned write no push");
        rdchk(a_msg(0), 32'hF0, "R3 pop F0");
        wr(12'h138, 32'hFF);
        for (int u = 0; u < 3; u++) rdchk(a_set(u), 0, "R13 no enable from phantom user");
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_revision();
        t_order();
        t_overflow();
        t_newmsg();
        t_notfull();
        t_enable();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule